// File: doc/BRIEF.md
# Execute-in-place cache control and access gate

This block sits in front of an execute-in-place flash cache. It holds the cache's control word and routes each bus access it accepts. The access can be served from the cache, forwarded to flash, used to invalidate a cached line, passed to the cache memory used as plain SRAM, completed silently, or answered with a bus error. The block does not contain the tag store, the data RAM, the flash controller or the fill logic. It reaches each of them through a valid/ready request. Tag lookups come back as a one-cycle result carrying hit and line-valid flags.

Software writes the control word through a plain write strobe and reads it back at any time. The control word has three fields: cache enable, fault-on-bad-write and power-down. Power-down always wins over enable. Accesses are accepted one at a time. Each access ends with a single-cycle response pulse, and that pulse carries an error flag. Back-pressure works the same way on every request the block issues: a request raises valid and holds it, with a stable payload, until the cycle in which ready is also high. The block does not start its next step until that handshake completes.

Top module: `xcg_gate`

## Requirements
- R1: The control word carries enable at bit 0, fault-on-bad-write at bit 1 and power-down at bit 3. All other bits read as 0 and ignore writes. With no write strobe, the word stays unchanged.
- R2: After reset the control word reads 0x00000003 (enabled, fault-on-bad-write set, powered up), and the block is idle with acc_ready high.
- R3: A control write with bit 3 set stores power-down as 1 and enable as 0, whatever bit 0 holds. A later write that clears bit 3 can set enable again.
- R4: acc_kind encodes 0 = cacheable XIP read, 1 = write, 2 = cache-as-SRAM access, 3 = reserved. With enable at 0, an XIP read issues no tag lookup and goes straight to a flash request with flash_alloc at 0.
- R5: With enable at 1, an XIP read issues a tag lookup. A result with both tag_hit and tag_line_valid set produces a cache read request and no flash request.
- R6: With enable at 1, an XIP read whose lookup result is not a valid hit produces a flash request with flash_alloc at 1.
- R7: A write with acc_alias 0 returns no error, whatever the fault-on-bad-write setting. Unless the cache is powered down, the write issues a tag lookup, and a valid hit then produces a deallocate request. While powered down, it completes without a lookup.
- R8: A write with a nonzero acc_alias issues no downstream request. It gets an error response when fault-on-bad-write is 1 and a clean response when it is 0.
- R9: A cache-as-SRAM access gets an error response and issues no SRAM request while enable or power-down is 1. Otherwise it issues an SRAM request.
- R10: Every accepted access ends with resp_valid high for exactly one cycle. That pulse comes in the cycle after the last downstream handshake, or in the cycle after acceptance when no request is issued. resp_err is meaningful only with resp_valid.
- R11: acc_ready is high only while no access is in progress. A request valid stays high, with a stable payload, until its ready is seen. At most one of the request valids and resp_valid is high in any cycle.
- R12: An access with the reserved kind 3 gets an error response and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W | Control word write data |
| cfg_rdata | output | CFG_W | Control word read-back |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle, access taken when valid |
| acc_kind | input | 2 | Access type (R4 encoding) |
| acc_alias | input | ALIAS_W | Address alias of the access |
| tag_req_valid | output | 1 | Tag lookup request |
| tag_req_ready | input | 1 | Tag lookup accepted |
| tag_rsp_valid | input | 1 | Tag lookup result present |
| tag_hit | input | 1 | Tag matched |
| tag_line_valid | input | 1 | Matched line valid bit |
| flash_req_valid | output | 1 | Flash read request |
| flash_req_ready | input | 1 | Flash request accepted |
| flash_alloc | output | 1 | Flash read should fill the cache |
| cache_rd_valid | output | 1 | Serve-from-cache request |
| cache_rd_ready | input | 1 | Cache read accepted |
| dealloc_valid | output | 1 | Invalidate matched line |
| dealloc_ready | input | 1 | Invalidate accepted |
| sram_req_valid | output | 1 | Cache-as-SRAM access request |
| sram_req_ready | input | 1 | SRAM access accepted |
| resp_valid | output | 1 | Access completion pulse |
| resp_err | output | 1 | Completion is a bus error |

## Verification
The bench rewrites the control word at random while accesses are in flight. A design that decided an access from the new value, instead of the value held at acceptance, would route it differently from the model. Control writes that set both enable and power-down catch a design that lets enable survive, because a later XIP read would then issue a tag lookup instead of a plain flash request. Alias-0 writes are mixed with fault-on-bad-write set. This exposes a design that faults every write, or one that skips the invalidate after a hit. Ready signals are held low for random stretches, so a request that dropped its valid early, or an access accepted before the response pulse, shows up as a mismatch against the model.

// File: rtl/xcg_pkg.sv
package xcg_pkg;

  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned BADW_BIT = 1;
  localparam int unsigned PD_BIT   = 3;

  typedef enum logic [1:0] {
    KIND_XIP_RD = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_SRAM   = 2'd2,
    KIND_RSVD   = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    RT_FLASH,
    RT_LOOKUP_RD,
    RT_LOOKUP_WR,
    RT_SRAM,
    RT_FAULT,
    RT_DONE
  } route_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG_REQ,
    ST_TAG_WAIT,
    ST_FLASH,
    ST_CACHE,
    ST_DEALLOC,
    ST_SRAM,
    ST_RESP
  } gate_state_e;

  typedef struct packed {
    logic enable;
    logic bad_wr_fault;
    logic power_dn;
  } cfg_t;

endpackage

// File: rtl/xcg_ctrl_reg.sv
module xcg_ctrl_reg
  import xcg_pkg::*;
#(
  parameter int unsigned CFG_W    = 32,
  parameter bit          RST_EN   = 1'b1,
  parameter bit          RST_BADW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata
);

  cfg_t cfg_q;

  // Power-down takes priority: enable can only be stored while bit 3 is clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.enable       <= RST_EN;
      cfg_q.bad_wr_fault <= RST_BADW;
      cfg_q.power_dn     <= 1'b0;
    end else if (we) begin
      cfg_q.enable       <= wdata[EN_BIT] & ~wdata[PD_BIT];
      cfg_q.bad_wr_fault <= wdata[BADW_BIT];
      cfg_q.power_dn     <= wdata[PD_BIT];
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[EN_BIT]   = cfg_q.enable;
    rdata[BADW_BIT] = cfg_q.bad_wr_fault;
    rdata[PD_BIT]   = cfg_q.power_dn;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/xcg_router.sv
module xcg_router
  import xcg_pkg::*;
#(
  parameter int unsigned ALIAS_W = 2
) (
  input  logic [1:0]         kind,
  input  logic [ALIAS_W-1:0] alias_sel,
  input  cfg_t               cfg,
  output route_e             route
);

  localparam logic [ALIAS_W-1:0] ALLOC_ALIAS = '0;

  always_comb begin
    route = RT_FAULT;
    unique case (acc_kind_e'(kind))
      KIND_XIP_RD: route = cfg.enable ? RT_LOOKUP_RD : RT_FLASH;
      KIND_WRITE: begin
        if (alias_sel == ALLOC_ALIAS)
          route = cfg.power_dn ? RT_DONE : RT_LOOKUP_WR;
        else
          route = cfg.bad_wr_fault ? RT_FAULT : RT_DONE;
      end
      KIND_SRAM:  route = (cfg.enable || cfg.power_dn) ? RT_FAULT : RT_SRAM;
      KIND_RSVD:  route = RT_FAULT;
      default:    route = RT_FAULT;
    endcase
  end

endmodule

// File: rtl/xcg_seq.sv
module xcg_seq
  import xcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc_valid,
  output logic   acc_ready,
  input  route_e route,
  output logic   tag_req_valid,
  input  logic   tag_req_ready,
  input  logic   tag_rsp_valid,
  input  logic   tag_hit,
  input  logic   tag_line_valid,
  output logic   flash_req_valid,
  input  logic   flash_req_ready,
  output logic   flash_alloc,
  output logic   cache_rd_valid,
  input  logic   cache_rd_ready,
  output logic   dealloc_valid,
  input  logic   dealloc_ready,
  output logic   sram_req_valid,
  input  logic   sram_req_ready,
  output logic   resp_valid,
  output logic   resp_err
);

  gate_state_e state_q, state_d;
  logic        alloc_q, alloc_d;
  logic        err_q, err_d;
  logic        wr_q, wr_d;
  logic        good_hit;

  assign good_hit = tag_hit & tag_line_valid;

  always_comb begin
    state_d = state_q;
    alloc_d = alloc_q;
    err_d   = err_q;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_valid) begin
          alloc_d = 1'b0;
          err_d   = 1'b0;
          wr_d    = 1'b0;
          unique case (route)
            RT_FLASH:     state_d = ST_FLASH;
            RT_LOOKUP_RD: state_d = ST_TAG_REQ;
            RT_LOOKUP_WR: begin
              state_d = ST_TAG_REQ;
              wr_d    = 1'b1;
            end
            RT_SRAM:      state_d = ST_SRAM;
            RT_FAULT: begin
              state_d = ST_RESP;
              err_d   = 1'b1;
            end
            RT_DONE:      state_d = ST_RESP;
            default: begin
              state_d = ST_RESP;
              err_d   = 1'b1;
            end
          endcase
        end
      end
      ST_TAG_REQ:  if (tag_req_ready) state_d = ST_TAG_WAIT;
      ST_TAG_WAIT: begin
        if (tag_rsp_valid) begin
          if (good_hit) begin
            state_d = wr_q ? ST_DEALLOC : ST_CACHE;
          end else if (wr_q) begin
            state_d = ST_RESP;
          end else begin
            state_d = ST_FLASH;
            alloc_d = 1'b1;
          end
        end
      end
      ST_FLASH:    if (flash_req_ready) state_d = ST_RESP;
      ST_CACHE:    if (cache_rd_ready)  state_d = ST_RESP;
      ST_DEALLOC:  if (dealloc_ready)   state_d = ST_RESP;
      ST_SRAM:     if (sram_req_ready)  state_d = ST_RESP;
      ST_RESP:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      alloc_q <= 1'b0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      alloc_q <= alloc_d;
      err_q   <= err_d;
      wr_q    <= wr_d;
    end
  end

  assign acc_ready       = (state_q == ST_IDLE);
  assign tag_req_valid   = (state_q == ST_TAG_REQ);
  assign flash_req_valid = (state_q == ST_FLASH);
  assign flash_alloc     = (state_q == ST_FLASH) & alloc_q;
  assign cache_rd_valid  = (state_q == ST_CACHE);
  assign dealloc_valid   = (state_q == ST_DEALLOC);
  assign sram_req_valid  = (state_q == ST_SRAM);
  assign resp_valid      = (state_q == ST_RESP);
  assign resp_err        = (state_q == ST_RESP) & err_q;

endmodule

// File: rtl/xcg_gate.sv
module xcg_gate
  import xcg_pkg::*;
#(
  parameter int unsigned ALIAS_W = 2,
  parameter int unsigned CFG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic [1:0]         acc_kind,
  input  logic [ALIAS_W-1:0] acc_alias,
  output logic               tag_req_valid,
  input  logic               tag_req_ready,
  input  logic               tag_rsp_valid,
  input  logic               tag_hit,
  input  logic               tag_line_valid,
  output logic               flash_req_valid,
  input  logic               flash_req_ready,
  output logic               flash_alloc,
  output logic               cache_rd_valid,
  input  logic               cache_rd_ready,
  output logic               dealloc_valid,
  input  logic               dealloc_ready,
  output logic               sram_req_valid,
  input  logic               sram_req_ready,
  output logic               resp_valid,
  output logic               resp_err
);

  cfg_t   cfg;
  route_e route;

  xcg_ctrl_reg #(.CFG_W(CFG_W)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  xcg_router #(.ALIAS_W(ALIAS_W)) router_i (
    .kind      (acc_kind),
    .alias_sel (acc_alias),
    .cfg       (cfg),
    .route     (route)
  );

  xcg_seq seq_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_ready       (acc_ready),
    .route           (route),
    .tag_req_valid   (tag_req_valid),
    .tag_req_ready   (tag_req_ready),
    .tag_rsp_valid   (tag_rsp_valid),
    .tag_hit         (tag_hit),
    .tag_line_valid  (tag_line_valid),
    .flash_req_valid (flash_req_valid),
    .flash_req_ready (flash_req_ready),
    .flash_alloc     (flash_alloc),
    .cache_rd_valid  (cache_rd_valid),
    .cache_rd_ready  (cache_rd_ready),
    .dealloc_valid   (dealloc_valid),
    .dealloc_ready   (dealloc_ready),
    .sram_req_valid  (sram_req_valid),
    .sram_req_ready  (sram_req_ready),
    .resp_valid      (resp_valid),
    .resp_err        (resp_err)
  );

endmodule

// File: rtl/xcg_gate_chk.sv
module xcg_gate_chk #(
  parameter int unsigned ALIAS_W = 2,
  parameter int unsigned CFG_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [CFG_W-1:0]   cfg_wdata,
  input logic [CFG_W-1:0]   cfg_rdata,
  input logic               acc_valid,
  input logic               acc_ready,
  input logic [1:0]         acc_kind,
  input logic [ALIAS_W-1:0] acc_alias,
  input logic               tag_req_valid,
  input logic               tag_req_ready,
  input logic               tag_rsp_valid,
  input logic               tag_hit,
  input logic               tag_line_valid,
  input logic               flash_req_valid,
  input logic               flash_req_ready,
  input logic               flash_alloc,
  input logic               cache_rd_valid,
  input logic               cache_rd_ready,
  input logic               dealloc_valid,
  input logic               dealloc_ready,
  input logic               sram_req_valid,
  input logic               sram_req_ready,
  input logic               resp_valid,
  input logic               resp_err
);

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R3
  pd_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[3] |=> cfg_rdata[3] && !cfg_rdata[0]);

  // R5
  cache_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cache_rd_valid) |-> $past(tag_rsp_valid && tag_hit && tag_line_valid));

  // R6
  alloc_after_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_req_valid) && flash_alloc |-> $past(tag_rsp_valid));

  // R9
  sram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_req_valid) |-> $past(!cfg_rdata[0] && !cfg_rdata[3]));

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && acc_ready);

  // R10
  err_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);

  // R11
  flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req_valid && !flash_req_ready |=> flash_req_valid && $stable(flash_alloc));

  // R11
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req_valid && !tag_req_ready |=> tag_req_valid);

  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tag_req_valid, flash_req_valid, cache_rd_valid,
              dealloc_valid, sram_req_valid, resp_valid}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !(tag_req_valid || flash_req_valid || cache_rd_valid ||
                    dealloc_valid || sram_req_valid || resp_valid));

endmodule

bind xcg_gate xcg_gate_chk #(.ALIAS_W(ALIAS_W), .CFG_W(CFG_W)) chk_i (.*);

// File: tb/xcg_gate_tb_top.sv
module xcg_gate_tb_top;

  localparam int ALIAS_W = 2;
  localparam int CFG_W   = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [CFG_W-1:0]   cfg_wdata = '0;
  logic [CFG_W-1:0]   cfg_rdata;
  logic               acc_valid = 1'b0;
  logic               acc_ready;
  logic [1:0]         acc_kind = '0;
  logic [ALIAS_W-1:0] acc_alias = '0;
  logic               tag_req_valid;
  logic               tag_req_ready = 1'b0;
  logic               tag_rsp_valid = 1'b0;
  logic               tag_hit = 1'b0;
  logic               tag_line_valid = 1'b0;
  logic               flash_req_valid;
  logic               flash_req_ready = 1'b0;
  logic               flash_alloc;
  logic               cache_rd_valid;
  logic               cache_rd_ready = 1'b0;
  logic               dealloc_valid;
  logic               dealloc_ready = 1'b0;
  logic               sram_req_valid;
  logic               sram_req_ready = 1'b0;
  logic               resp_valid;
  logic               resp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcg_gate #(.ALIAS_W(ALIAS_W), .CFG_W(CFG_W)) dut_i (.*);

  // Behavioural reference: what the access is waiting on, plus the control word.
  bit m_en, m_bw, m_pd;
  string m_wait;   // "idle","tagreq","tagrsp","flash","cache","dealloc","sram","resp"
  bit m_alloc, m_err, m_isw;

  task automatic expect_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [CFG_W-1:0] exp_word;
    exp_word = '0;
    exp_word[0] = m_en;
    exp_word[1] = m_bw;
    exp_word[3] = m_pd;
    checks++;
    if (cfg_rdata !== exp_word) begin
      errors++;
      $display("FAIL R1 R2 R3 cfg_rdata actual=%h expected=%h", cfg_rdata, exp_word);
    end
    expect_bit("R11", "acc_ready", acc_ready, m_wait == "idle");
    expect_bit("R5 R7", "tag_req_valid", tag_req_valid, m_wait == "tagreq");
    expect_bit("R4 R6", "flash_req_valid", flash_req_valid, m_wait == "flash");
    expect_bit("R6 R4", "flash_alloc", flash_alloc, (m_wait == "flash") && m_alloc);
    expect_bit("R5", "cache_rd_valid", cache_rd_valid, m_wait == "cache");
    expect_bit("R7", "dealloc_valid", dealloc_valid, m_wait == "dealloc");
    expect_bit("R9", "sram_req_valid", sram_req_valid, m_wait == "sram");
    expect_bit("R10", "resp_valid", resp_valid, m_wait == "resp");
    expect_bit("R8 R12", "resp_err", resp_err, (m_wait == "resp") && m_err);
  endtask

  // Advance the model by one clock using the inputs now on the pins.
  task automatic model_step();
    bit en0, bw0, pd0;
    en0 = m_en; bw0 = m_bw; pd0 = m_pd;
    if (m_wait == "idle") begin
      if (acc_valid) begin
        m_alloc = 0; m_err = 0; m_isw = 0;
        if (acc_kind == 2'd0) begin
          if (en0) m_wait = "tagreq"; else m_wait = "flash";
        end else if (acc_kind == 2'd1) begin
          if (acc_alias != 0) begin
            m_err = bw0; m_wait = "resp";
          end else if (pd0) begin
            m_wait = "resp";
          end else begin
            m_isw = 1; m_wait = "tagreq";
          end
        end else if (acc_kind == 2'd2) begin
          if (en0 || pd0) begin m_err = 1; m_wait = "resp"; end
          else m_wait = "sram";
        end else begin
          m_err = 1; m_wait = "resp";
        end
      end
    end else if (m_wait == "tagreq") begin
      if (tag_req_ready) m_wait = "tagrsp";
    end else if (m_wait == "tagrsp") begin
      if (tag_rsp_valid) begin
        if (tag_hit && tag_line_valid) m_wait = m_isw ? "dealloc" : "cache";
        else if (m_isw) m_wait = "resp";
        else begin m_wait = "flash"; m_alloc = 1; end
      end
    end else if (m_wait == "flash") begin
      if (flash_req_ready) m_wait = "resp";
    end else if (m_wait == "cache") begin
      if (cache_rd_ready) m_wait = "resp";
    end else if (m_wait == "dealloc") begin
      if (dealloc_ready) m_wait = "resp";
    end else if (m_wait == "sram") begin
      if (sram_req_ready) m_wait = "resp";
    end else begin
      m_wait = "idle";
    end
    if (cfg_we) begin
      m_pd = cfg_wdata[3];
      m_bw = cfg_wdata[1];
      m_en = cfg_wdata[0] && !cfg_wdata[3];
    end
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    compare();
    cfg_we = 1'b0;
  endtask

  task automatic set_readies(input bit r);
    tag_req_ready = r; flash_req_ready = r; cache_rd_ready = r;
    dealloc_ready = r; sram_req_ready = r;
  endtask

  task automatic cfg_write(input logic [CFG_W-1:0] v);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_wdata = v;
    cycle();
  endtask

  // One access with all readies high; hit/valid on the lookup response.
  task automatic access(input logic [1:0] k, input logic [ALIAS_W-1:0] a, input bit hit, input bit lv);
    acc_valid = 1'b1; acc_kind = k; acc_alias = a;
    tag_rsp_valid = 1'b1; tag_hit = hit; tag_line_valid = lv;
    set_readies(1'b1);
    cycle();
    acc_valid = 1'b0;
    for (int i = 0; i < 6; i++) cycle();
  endtask

  initial begin
    m_en = 1; m_bw = 1; m_pd = 0; m_wait = "idle";
    m_alloc = 0; m_err = 0; m_isw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();  // R2 reset state

    access(2'd0, 0, 1, 1);            // R5 hit while enabled
    access(2'd0, 0, 1, 0);            // R6 tag hit but line invalid
    access(2'd1, 2, 0, 0);            // R8 bad write faults
    access(2'd1, 0, 1, 1);            // R7 alias-0 write hit with fault on
    access(2'd2, 0, 0, 0);            // R9 SRAM while enabled
    access(2'd3, 1, 0, 0);            // R12 reserved kind
    cfg_write(32'hFFFF_FFFF);         // R1 R3 only fields stored, pd wins
    access(2'd0, 0, 1, 1);            // R4 powered down: straight to flash
    access(2'd2, 0, 0, 0);            // R9 SRAM while powered down
    access(2'd1, 0, 1, 1);            // R7 alias-0 write while powered down
    cfg_write(32'h0000_0000);         // R8 fault off
    access(2'd1, 3, 0, 0);            // R8 dropped quietly
    access(2'd2, 0, 0, 0);            // R9 SRAM allowed
    access(2'd0, 0, 0, 0);            // R4 disabled read
    cfg_write(32'h0000_0009);         // R3 both set
    cfg_write(32'h0000_0001);         // R3 enable again after pd clear
    access(2'd0, 0, 0, 1);            // R6 miss allocates

    // Random traffic with back-pressure and control writes mid-flight (R10 R11).
    for (int n = 0; n < 20000; n++) begin
      acc_valid      = ($urandom_range(0, 2) != 0);
      acc_kind       = 2'($urandom_range(0, 3));
      acc_alias      = ($urandom_range(0, 1) != 0) ? '0 : ALIAS_W'($urandom);
      tag_req_ready  = $urandom_range(0, 1) != 0;
      tag_rsp_valid  = $urandom_range(0, 2) != 0;
      tag_hit        = $urandom_range(0, 1) != 0;
      tag_line_valid = $urandom_range(0, 3) != 0;
      flash_req_ready = $urandom_range(0, 2) != 0;
      cache_rd_ready  = $urandom_range(0, 1) != 0;
      dealloc_ready   = $urandom_range(0, 1) != 0;
      sram_req_ready  = $urandom_range(0, 2) != 0;
      if ($urandom_range(0, 29) == 0) begin
        cfg_we    = 1'b1;
        cfg_wdata = $urandom;
      end
      cycle();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule